// File: doc/BRIEF.md
# Interleaving Phase-Shift Controller

This block keeps a secondary boundary-conduction converter stage running half a switching period behind a primary stage. It does this without touching the secondary stage's timing directly. Each stage reports its inductor-current zero crossings as single-cycle pulses. The block times the primary period and the delay from the latest primary crossing to each secondary crossing. On every secondary crossing it computes a new peak-current setpoint for the secondary stage. The stage period grows with peak current, so changing the secondary's current moves its next crossing earlier or later.

The setpoint has three parts. The first is a feedforward term equal to the primary stage's peak-current setpoint. The second is a proportional correction: the required period change multiplied by the reciprocal of the period-versus-current slope at the present operating point, which is supplied in Q8.8 format. The third is an integral trim that removes the static phase error left by mismatched stages. The result is clamped to a programmable current range. Because of that clamp, a large phase error can take several periods to remove. While the output is clamped the trim is frozen, and the trim itself saturates at programmable bounds. The charging controller drops an enable shortly before the output voltage target is reached, and this switches the secondary stage off.

Top module: `ipsc_ctrl`

## Requirements
- R1: The primary period P is the number of clock cycles between two consecutive primary pulses. A period measured by a primary pulse in the same cycle as a secondary pulse is used by that update.
- R2: The raw shift is the number of cycles from the latest primary pulse to the secondary pulse, and 0 when both pulses share a cycle. A raw shift at or above P is reduced by P once. If it is still at or above P, it is held at P-1.
- R3: The phase error is E = shift - floor(P/2). The proportional correction is floor(-E * K / 256), where K is the unsigned Q8.8 reciprocal slope.
- R4: At each update the output becomes the clamp of (primary setpoint + trim + correction) to [i_min, i_max]. The lower bound is tested first. The output is registered at the edge that samples the secondary pulse and holds between updates.
- R5: After an unclamped update the trim becomes trim + floor(-E / 2^ki_shift). If that value is above trim_hi it becomes trim_hi; otherwise, if it is below trim_lo, it becomes trim_lo. The new trim applies from the next update.
- R6: An update whose sum falls outside [i_min, i_max] leaves the trim unchanged (anti-windup).
- R7: While sec_enable is low, the output is 0 from the next cycle, the trim is reset to 0 and no update occurs.
- R8: No update occurs until two primary pulses have been seen since reset.
- R9: upd_strobe is high for exactly the one cycle after each update edge and never otherwise.
- R10: Reset drives the output to 0, the trim to 0 and upd_strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing counts use it |
| rst_n | input | 1 | Active-low synchronous reset |
| zc_pri | input | 1 | Primary stage zero-crossing pulse |
| zc_sec | input | 1 | Secondary stage zero-crossing pulse; triggers an update |
| sec_enable | input | 1 | Secondary stage enable; low forces it off |
| ipk_pri | input | IW (16) | Primary peak-current setpoint (feedforward) |
| inv_slope | input | SLW (16) | Reciprocal period-versus-current slope, Q8.8 unsigned |
| ki_shift | input | KSW (4) | Integral gain as a right shift of the negated error |
| trim_lo | input | TW (16) | Lower trim bound, signed |
| trim_hi | input | TW (16) | Upper trim bound, signed |
| i_min | input | IW (16) | Lowest permitted secondary setpoint |
| i_max | input | IW (16) | Highest permitted secondary setpoint |
| ipk_sec | output | IW (16) | Secondary peak-current setpoint |
| upd_strobe | output | 1 | One-cycle pulse after each update |

## Verification
The update law is driven with directed shifts that separate its branches. A shift of exactly half a period isolates the feedforward and trim terms. Shifts below and above half a period fix the sign of the correction. A shift of zero exercises the coincident-pulse case. Shifts past one and past two periods exercise the wrap and the hold. An odd period checks that the half-period target rounds down. A narrow current limit and a narrow trim bound make the clamp and the anti-windup freeze visible, because the outputs of later updates reveal the trim that was kept. Random periods, shifts, slopes, gains and feedforward values, checked against a bench model of the law, catch errors in rounding and sign extension.

// File: rtl/ipsc_pkg.sv
package ipsc_pkg;
    // Fraction bits of the reciprocal slope input.
    localparam int unsigned SLOPE_FRAC = 8;

    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_LOW  = 2'd1,
        CLAMP_HIGH = 2'd2
    } clamp_e;
endpackage

// File: rtl/ipsc_zc_timer.sv
// Times the primary period and reports the running delay since the
// latest primary zero crossing.
module ipsc_zc_timer #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          zc_pri,
    output logic [CW-1:0] period_now,
    output logic          period_ok,
    output logic [CW-1:0] shift_raw
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] period;
        logic          seen;
        logic          ok;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (zc_pri) begin
            st_d.cnt = {{(CW-1){1'b0}}, 1'b1};
            if (st_q.seen) begin
                st_d.period = st_q.cnt;
                st_d.ok     = 1'b1;
            end
            st_d.seen = 1'b1;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A measurement finishing this cycle is visible to this cycle's update.
    assign period_now = (zc_pri && st_q.seen) ? st_q.cnt : st_q.period;
    assign period_ok  = st_q.ok | (zc_pri & st_q.seen);
    assign shift_raw  = zc_pri ? '0 : st_q.cnt;
endmodule

// File: rtl/ipsc_phase_law.sv
// Combinational update law: phase error, slope-scaled correction,
// output clamp and saturating integral trim.
module ipsc_phase_law
    import ipsc_pkg::*;
#(
    parameter int unsigned CW  = 16,
    parameter int unsigned IW  = 16,
    parameter int unsigned TW  = 16,
    parameter int unsigned SLW = 16,
    parameter int unsigned KSW = 4
) (
    input  logic [CW-1:0]         period,
    input  logic [CW-1:0]         shift_raw,
    input  logic [IW-1:0]         ipk_pri,
    input  logic [SLW-1:0]        inv_slope,
    input  logic [KSW-1:0]        ki_shift,
    input  logic signed [TW-1:0]  trim,
    input  logic signed [TW-1:0]  trim_lo,
    input  logic signed [TW-1:0]  trim_hi,
    input  logic [IW-1:0]         i_min,
    input  logic [IW-1:0]         i_max,
    output logic [IW-1:0]         out_next,
    output logic signed [TW-1:0]  trim_next,
    output clamp_e                clamp
);
    localparam int unsigned EW   = CW + 2;
    localparam int unsigned PW   = EW + SLW + 1;
    localparam int unsigned SUMW = PW + 2;
    localparam int unsigned TSW  = ((TW > EW) ? TW : EW) + 1;

    logic [CW-1:0]          half;
    logic [CW-1:0]          over;
    logic [CW-1:0]          shift_m;
    logic signed [EW-1:0]   err;
    logic signed [EW-1:0]   neg_err;
    logic signed [PW-1:0]   prod;
    logic signed [PW-1:0]   corr;
    logic signed [SUMW-1:0] sum;
    logic signed [SUMW-1:0] lo_s;
    logic signed [SUMW-1:0] hi_s;
    logic signed [EW-1:0]   inc;
    logic signed [TSW-1:0]  tsum;

    always_comb begin
        half = period >> 1;
        over = shift_raw - period;
        if (shift_raw < period) begin
            shift_m = shift_raw;
        end else if (over < period) begin
            shift_m = over;
        end else begin
            shift_m = period - 1'b1;
        end

        err     = $signed({2'b00, shift_m}) - $signed({2'b00, half});
        neg_err = -err;
        prod    = neg_err * $signed({1'b0, inv_slope});
        corr    = prod >>> SLOPE_FRAC;

        sum  = SUMW'($signed({1'b0, ipk_pri})) + SUMW'(trim) + SUMW'(corr);
        lo_s = SUMW'($signed({1'b0, i_min}));
        hi_s = SUMW'($signed({1'b0, i_max}));

        if (sum < lo_s) begin
            out_next = i_min;
            clamp    = CLAMP_LOW;
        end else if (sum > hi_s) begin
            out_next = i_max;
            clamp    = CLAMP_HIGH;
        end else begin
            out_next = sum[IW-1:0];
            clamp    = CLAMP_NONE;
        end

        inc  = neg_err >>> ki_shift;
        tsum = TSW'(trim) + TSW'(inc);
        if (tsum > TSW'(trim_hi)) begin
            trim_next = trim_hi;
        end else if (tsum < TSW'(trim_lo)) begin
            trim_next = trim_lo;
        end else begin
            trim_next = tsum[TW-1:0];
        end
    end
endmodule

// File: rtl/ipsc_ctrl.sv
// Top: interleaving phase-shift controller for a secondary stage.
module ipsc_ctrl
    import ipsc_pkg::*;
#(
    parameter int unsigned CW  = 16,
    parameter int unsigned IW  = 16,
    parameter int unsigned TW  = 16,
    parameter int unsigned SLW = 16,
    parameter int unsigned KSW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  zc_pri,
    input  logic                  zc_sec,
    input  logic                  sec_enable,
    input  logic [IW-1:0]         ipk_pri,
    input  logic [SLW-1:0]        inv_slope,
    input  logic [KSW-1:0]        ki_shift,
    input  logic signed [TW-1:0]  trim_lo,
    input  logic signed [TW-1:0]  trim_hi,
    input  logic [IW-1:0]         i_min,
    input  logic [IW-1:0]         i_max,
    output logic [IW-1:0]         ipk_sec,
    output logic                  upd_strobe
);
    typedef struct packed {
        logic [IW-1:0]        out;
        logic signed [TW-1:0] trim;
        logic                 strobe;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [CW-1:0]        period_now;
    logic                 period_ok;
    logic [CW-1:0]        shift_raw;
    logic [IW-1:0]        law_out;
    logic signed [TW-1:0] law_trim;
    clamp_e               law_clamp;

    ipsc_zc_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .zc_pri     (zc_pri),
        .period_now (period_now),
        .period_ok  (period_ok),
        .shift_raw  (shift_raw)
    );

    ipsc_phase_law #(
        .CW(CW), .IW(IW), .TW(TW), .SLW(SLW), .KSW(KSW)
    ) u_law (
        .period    (period_now),
        .shift_raw (shift_raw),
        .ipk_pri   (ipk_pri),
        .inv_slope (inv_slope),
        .ki_shift  (ki_shift),
        .trim      (st_q.trim),
        .trim_lo   (trim_lo),
        .trim_hi   (trim_hi),
        .i_min     (i_min),
        .i_max     (i_max),
        .out_next  (law_out),
        .trim_next (law_trim),
        .clamp     (law_clamp)
    );

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (!sec_enable) begin
            st_d.out  = '0;
            st_d.trim = '0;
        end else if (zc_sec && period_ok) begin
            st_d.out    = law_out;
            st_d.strobe = 1'b1;
            if (law_clamp == CLAMP_NONE) begin
                st_d.trim = law_trim;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ipk_sec    = st_q.out;
    assign upd_strobe = st_q.strobe;
endmodule

// File: rtl/ipsc_ctrl_chk.sv
module ipsc_ctrl_chk #(
    parameter int unsigned IW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          zc_sec,
    input logic          sec_enable,
    input logic [IW-1:0] i_min,
    input logic [IW-1:0] i_max,
    input logic [IW-1:0] ipk_sec,
    input logic          upd_strobe
);
    assert_off_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_enable |=> (ipk_sec == '0));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_enable && !zc_sec) |=> $stable(ipk_sec));

    assert_strobe_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |-> ($past(zc_sec) && $past(sec_enable)));

    assert_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_strobe && ($past(i_min) <= $past(i_max)))
        |-> ((ipk_sec >= $past(i_min)) && (ipk_sec <= $past(i_max))));
endmodule

bind ipsc_ctrl ipsc_ctrl_chk #(.IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .zc_sec     (zc_sec),
    .sec_enable (sec_enable),
    .i_min      (i_min),
    .i_max      (i_max),
    .ipk_sec    (ipk_sec),
    .upd_strobe (upd_strobe)
);

// File: tb/ipsc_ctrl_bench.sv
`timescale 1ns/1ps
module ipsc_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        zc_pri = 1'b0;
    logic        zc_sec = 1'b0;
    logic        sec_enable = 1'b0;
    logic [15:0] ipk_pri = 16'd0;
    logic [15:0] inv_slope = 16'd0;
    logic [3:0]  ki_shift = 4'd0;
    logic signed [15:0] trim_lo = 16'sd0;
    logic signed [15:0] trim_hi = 16'sd0;
    logic [15:0] i_min = 16'd0;
    logic [15:0] i_max = 16'd0;
    logic [15:0] ipk_sec;
    logic        upd_strobe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    longint m_trim = 0;
    longint m_exp = 0;

    always #2 clk = ~clk;

    ipsc_ctrl u_ipsc_ctrl (
        .clk(clk), .rst_n(rst_n), .zc_pri(zc_pri), .zc_sec(zc_sec),
        .sec_enable(sec_enable), .ipk_pri(ipk_pri), .inv_slope(inv_slope),
        .ki_shift(ki_shift), .trim_lo(trim_lo), .trim_hi(trim_hi),
        .i_min(i_min), .i_max(i_max), .ipk_sec(ipk_sec), .upd_strobe(upd_strobe)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input bit p, input bit s);
        zc_pri = p;
        zc_sec = s;
        @(posedge clk);
        #1;
        zc_pri = 1'b0;
        zc_sec = 1'b0;
    endtask

    // Primary pulse, primary pulse P later, secondary pulse S after that.
    task automatic pulses(input int p, input int s);
        tick(1'b1, 1'b0);
        repeat (p - 1) tick(1'b0, 1'b0);
        if (s == 0) begin
            tick(1'b1, 1'b1);
        end else begin
            tick(1'b1, 1'b0);
            repeat (s - 1) tick(1'b0, 1'b0);
            tick(1'b0, 1'b1);
        end
    endtask

    // Bench model of the update law (R2, R3, R4, R5, R6).
    function automatic void model(input int p, input int s);
        longint sm, err, neg, corr, sum, t;
        bit cl;
        if (s < p) sm = s;
        else if (s - p < p) sm = s - p;
        else sm = p - 1;
        err  = sm - (p / 2);
        neg  = -err;
        corr = (neg * longint'(inv_slope)) >>> 8;
        sum  = longint'(ipk_pri) + m_trim + corr;
        cl   = 1'b1;
        if (sum < longint'(i_min)) m_exp = i_min;
        else if (sum > longint'(i_max)) m_exp = i_max;
        else begin
            m_exp = sum;
            cl = 1'b0;
        end
        if (!cl) begin
            t = m_trim + (neg >>> ki_shift);
            if (t > longint'(trim_hi)) t = trim_hi;
            else if (t < longint'(trim_lo)) t = trim_lo;
            m_trim = t;
        end
    endfunction

    task automatic do_update(input string req, input int p, input int s);
        pulses(p, s);
        model(p, s);
        chk(req, ipk_sec, m_exp);
        chk({req, " R9 strobe"}, upd_strobe, 1);
        tick(1'b0, 1'b0);
        chk("R9 strobe drop", upd_strobe, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = $urandom(32'd4242);
        ipk_pri   = 16'd20000;
        inv_slope = 16'd256;
        ki_shift  = 4'd2;
        trim_lo   = -16'sd3000;
        trim_hi   = 16'sd3000;
        i_min     = 16'd100;
        i_max     = 16'd60000;
        repeat (3) tick(1'b0, 1'b0);
        chk("R10 reset output", ipk_sec, 0);
        chk("R10 reset strobe", upd_strobe, 0);

        rst_n = 1'b1;
        sec_enable = 1'b1;
        // R8: only one primary pulse so far, secondary pulse ignored
        tick(1'b1, 1'b0);
        repeat (5) tick(1'b0, 1'b0);
        tick(1'b0, 1'b1);
        chk("R8 no update strobe", upd_strobe, 0);
        chk("R8 no update output", ipk_sec, 0);

        do_update("R3 zero error", 100, 50);
        do_update("R3 late shift", 100, 70);
        do_update("R3 early shift", 100, 20);
        do_update("R1 R2 coincident pulses", 100, 0);
        do_update("R2 wrap one period", 100, 150);
        do_update("R2 hold beyond two periods", 100, 250);
        do_update("R3 odd period", 101, 50);
        inv_slope = 16'd700;
        do_update("R3 fractional slope", 64, 9);
        do_update("R5 trim applied", 80, 40);

        // R6: clamp high, trim must stay frozen
        i_max = 16'd20010;
        do_update("R6 clamp high", 100, 5);
        i_max = 16'd60000;
        do_update("R6 trim kept after clamp", 100, 50);
        i_min = 16'd30000;
        do_update("R4 clamp low", 100, 50);
        i_min = 16'd100;

        // R5: trim saturation at upper bound
        ki_shift = 4'd0;
        inv_slope = 16'd256;
        trim_hi = 16'sd5;
        do_update("R5 trim saturates", 100, 10);
        do_update("R5 saturated trim used", 100, 50);
        trim_hi = 16'sd3000;

        // R7: disable forces zero and blocks updates
        sec_enable = 1'b0;
        tick(1'b0, 1'b0);
        chk("R7 off output", ipk_sec, 0);
        pulses(100, 30);
        chk("R7 off no strobe", upd_strobe, 0);
        chk("R7 off output held", ipk_sec, 0);
        m_trim = 0;
        sec_enable = 1'b1;
        do_update("R7 trim cleared", 100, 50);

        for (int i = 0; i < 40; i++) begin
            int p, s;
            p = 8 + int'($urandom_range(0, 192));
            s = int'($urandom_range(0, 2 * p - 1));
            ipk_pri   = 16'(1000 + $urandom_range(0, 49000));
            inv_slope = 16'($urandom_range(0, 1023));
            ki_shift  = 4'($urandom_range(0, 6));
            do_update("R4 random update", p, s);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule